// File: doc/BRIEF.md
# Sixtieth-Second Tick Counter with Wrap Interrupt

The block derives a 60 Hz tick from the system clock through a prescaler, counts the ticks in a 6-bit register, and raises a timer interrupt each time that count rolls over from 63 to 0. Software sees the interrupt as a sticky pending flag and as a one-cycle request pulse. The flag stays set until an acknowledge pulse clears it.

A read port is always live. It packs the pending flag and the count into one 7-bit word. A synchronous clear input zeroes the count, the flag and the prescaler, so the tick timing starts over from the cycle of the clear.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset, or in the cycle after `clr` is asserted, the count is 0, the pending flag is 0 and `irq_req` is low.
- R2: A tick occurs once every `CLKS_PER_TICK` system clocks. After reset or clear the first tick is taken at the end of the `CLKS_PER_TICK`-th cycle; the count therefore reads 1 after exactly `CLKS_PER_TICK` rising edges.
- R3: On a tick with a count below 63, the count increments by one, and the flag is unchanged.
- R4: On a tick with a count of 63, the count becomes 0 and the pending flag becomes 1.
- R5: `irq_req` is high for exactly one cycle, the cycle in which the flag is first seen set after a wrap, and is low at all other times.
- R6: `ack` clears the pending flag in the next cycle. When `ack` falls in the same cycle as a wrap, the flag is set anyway.
- R7: `rd_word` carries the pending flag in bit 6 and the count in bits 5:0 at all times.
- R8: `clr` takes priority over a tick and over `ack`. It also restarts the prescaler, so the next tick comes a full `CLKS_PER_TICK` cycles after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the count, flag and prescaler |
| ack | input | 1 | Interrupt acknowledge; clears the pending flag |
| rd_word | output | 7 | Read-timer word: {flag, count} |
| irq_req | output | 1 | One-cycle interrupt request pulse |

## Verification
Two events can fall in the same cycle: the acknowledge and the wrap that sets the flag. The bench lines `ack` up on the exact cycle of the 63-to-0 wrap. It then expects the flag to read 1 and the pulse to fire. The bench also drives `clr` on tick cycles and expects the clear to win. Random `ack` pulses run against a bench model of the counter.

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int CLKS_PER_TICK = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ack,
  output logic [CNT_W:0]   rd_word,
  output logic             irq_req
);
  localparam int PS_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLKS_PER_TICK - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             irq_q;

  wire tick = (ps_q == PS_LAST);
  wire wrap = tick && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (clr) begin
      ps_q   <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ps_q   <= tick ? '0 : ps_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
      if (wrap) flag_q <= 1'b1;
      else if (ack) flag_q <= 1'b0;
      irq_q  <= wrap;
    end
  end

  assign rd_word = {flag_q, cnt_q};
  assign irq_req = irq_q;

  p_prescale_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q <= PS_LAST);
  p_no_tick_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt_q));
  p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wrap) |=> (flag_q && cnt_q == '0));
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  p_irq_with_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> flag_q);
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap && !clr) |=> !flag_q);
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_word == '0 && !irq_req));
endmodule

// File: tb/rtc_tick_timer_tb_top.sv
module rtc_tick_timer_tb_top;
  localparam int P = 8;
  logic clk = 0, rst_n = 0, clr = 0, ack = 0;
  logic [6:0] rd_word;
  logic irq_req;
  int n_cmp = 0, n_bad = 0;
  int m_ps = 0, m_cnt = 0, m_flag = 0, m_irq = 0;

  rtc_tick_timer #(.CLKS_PER_TICK(P), .CNT_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ack(ack),
    .rd_word(rd_word), .irq_req(irq_req));

  always #10 clk = ~clk;

  function automatic logic [6:0] exp_word(int f, int c);
    return {f[0], c[5:0]};
  endfunction

  task automatic check(string req, logic [6:0] w, logic i);
    n_cmp++;
    if (rd_word !== w || irq_req !== i) begin
      n_bad++;
      $display("FAIL %s: got word=%h irq=%b expected word=%h irq=%b",
               req, rd_word, irq_req, w, i);
    end
  endtask

  task automatic step(logic c, logic a, string req);
    clr = c; ack = a;
    @(posedge clk);
    if (c) begin m_ps = 0; m_cnt = 0; m_flag = 0; m_irq = 0; end
    else begin
      automatic bit t = (m_ps == P-1);
      automatic bit w = t && (m_cnt == 63);
      m_ps = t ? 0 : m_ps + 1;
      if (t) m_cnt = (m_cnt + 1) % 64;
      if (w) m_flag = 1; else if (a) m_flag = 0;
      m_irq = w;
    end
    #5;
    check(req, exp_word(m_flag, m_cnt), m_irq[0]);
    clr = 0; ack = 0;
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #35; check("R1", 7'h00, 1'b0);
    rst_n = 1;
    for (int k = 0; k < P; k++) step(0, 0, "R2");
    step(0, 0, "R3");
    for (int k = 0; k < 63*P; k++) step(0, 0, "R4");
    step(0, 0, "R5");
    step(0, 1, "R6");
    step(1, 0, "R1");
    for (int k = 0; k < P-2; k++) step(0, 0, "R8");
    step(1, 0, "R8");
    for (int k = 0; k < P*3; k++) step(0, 0, "R8");
    while (!(m_cnt == 63 && m_ps == P-1)) step(0, 0, "R7");
    step(0, 1, "R6");
    for (int k = 0; k < 2; k++) step(0, 0, "R6");
    while (!(m_cnt == 63 && m_ps == P-1)) step(0, 0, "R7");
    step(1, 1, "R8");
    for (int k = 0; k < 3000; k++)
      step(($urandom % 500) == 0, ($urandom % 40) == 0, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule